// File: doc/BRIEF.md
# Repetition-Aware Double Scrambler

This block randomizes 64-bit frames on the transmit side of a serial link and undoes that randomization on the receive side. Each accepted frame is first XORed with the keystream of a 16-bit primary additive scrambler. The result then goes to a detector that looks for a short bit pattern repeated back to back. A periodic frame is the kind of content that concentrates spectral energy and raises EMI. When the detector fires, the frame is XORed a second time with the keystream of an independent 23-bit scrambler built on a different polynomial. Other frames go out with only the primary scrambling.

A one-bit flag travels with every frame and tells the receiver which path was taken. The receive path first removes the secondary keystream, and only from flagged frames. It then removes the primary keystream from every frame. Each of the four LFSRs advances only on the bits it actually processes, so the transmit and receive generators stay in lockstep.

Top module: `rep_scrambler_link`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `dec_valid` are 0. From the first clock edge after reset is released, `in_ready` is 1.
- R2: A frame is accepted on a rising edge where `in_valid` and `in_ready` are both 1. It appears on `out_valid`/`out_flag`/`out_data` after that same edge. On an edge with no acceptance, `out_valid` goes to 0.
- R3: The primary keystream comes from a Galois LFSR for x^16+x^5+x^4+x^3+1, with tap mask 0x0039 and seed 0xFFFF. For each of the 64 frame bits, taken from bit 63 down to bit 0, the key bit is the state MSB. The state then shifts left by one and is XORed with the mask if that MSB was 1. The state carries over from frame to frame.
- R4: The stage-1 result is flagged when, at any bit offset, it holds a run of L*M bits in which every bit equals the bit L positions above it. This means an L-bit pattern occurring M times in a row. The defaults are L=8 and M=5.
- R5: A flagged frame is additionally XORed with a secondary keystream. This keystream is generated by the rule of R3 from x^23+x^21+x^16+x^8+x^5+x^2+1, with mask 0x210125 and an all-ones 23-bit seed. The secondary LFSR advances 64 steps per flagged frame and holds on unflagged frames.
- R6: `out_flag` is 1 exactly when the secondary scrambling was applied to the frame. An unflagged frame leaves as the stage-1 result unchanged.
- R7: Every frame presented on `rx_valid` is decoded and appears on `dec_valid`/`dec_data` after the next clock edge. When the transmit output is fed back into the receive input, the decoded data equals the original input bit for bit.
- R8: The receive secondary LFSR advances only on frames with `rx_flag` = 1. This keeps decoding correct across any mix of flagged and unflagged frames.
- R9: A flagged frame leaves different from its stage-1 result. The frame is altered because 64 consecutive secondary key bits are never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Block can accept a frame |
| in_data | input | 64 | Raw frame to transmit |
| out_valid | output | 1 | Encoded frame valid |
| out_flag | output | 1 | Frame header bit: second scrambling applied |
| out_data | output | 64 | Encoded frame payload |
| rx_valid | input | 1 | Received frame valid |
| rx_flag | input | 1 | Received frame header bit |
| rx_data | input | 64 | Received frame payload |
| dec_valid | output | 1 | Decoded frame valid |
| dec_data | output | 64 | Recovered raw frame |

## Verification
The bench uses the defaults: a 64-bit frame, L=8 and M=5. With these values the 40-bit repeated run can start at any of 25 offsets. The bench places runs at offset 0, at offset 24 and at an offset that is not a multiple of 8. It also places a run of only four repeats with its edges broken, which sits just below the detection threshold. Repetitive frames are built by pre-XORing a chosen pattern with the bench's own model of the primary keystream, so the pattern appears after stage 1. Flagged and unflagged frames are interleaved, both back to back and with gaps, to show that both LFSR pairs stay aligned.

// File: rtl/rds_pkg.sv
package rds_pkg;
  localparam int FRAME_W = 64;
  localparam int PAT_L   = 8;
  localparam int PAT_M   = 5;
  localparam int PRI_W   = 16;
  localparam logic [PRI_W-1:0] PRI_MASK = 16'h0039;
  localparam logic [PRI_W-1:0] PRI_SEED = 16'hFFFF;
  localparam int SEC_W   = 23;
  localparam logic [SEC_W-1:0] SEC_MASK = 23'h210125;
  localparam logic [SEC_W-1:0] SEC_SEED = 23'h7FFFFF;
endpackage

// File: rtl/rds_lfsr.sv
module rds_lfsr #(
  parameter int SW = 16,
  parameter int FW = 64,
  parameter logic [SW-1:0] MASK = '1,
  parameter logic [SW-1:0] SEED = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [FW-1:0] key,
  output logic [SW-1:0] state
);
  // Unrolls FW Galois steps: returns {key, next_state}
  function automatic logic [FW+SW-1:0] unroll(input logic [SW-1:0] s);
    logic [FW-1:0] k;
    logic          msb;
    k = '0;
    for (int n = 0; n < FW; n++) begin
      msb = s[SW-1];
      k[FW-1-n] = msb;
      s = {s[SW-2:0], 1'b0} ^ (msb ? MASK : '0);
    end
    return {k, s};
  endfunction

  logic [SW-1:0] nxt;
  assign {key, nxt} = unroll(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/rds_repeat_det.sv
module rds_repeat_det #(
  parameter int FW = 64,
  parameter int L  = 8,
  parameter int M  = 5
) (
  input  logic [FW-1:0] bits,
  output logic          hit
);
  localparam int SPAN = L * (M - 1);

  // Count consecutive positions whose bit matches the one L above
  function automatic logic scan(input logic [FW-1:0] b);
    int  run;
    logic found;
    run = 0;
    found = 1'b0;
    for (int i = 0; i < FW - L; i++) begin
      if (b[i] == b[i+L]) run = run + 1;
      else                run = 0;
      if (run >= SPAN) found = 1'b1;
    end
    return found;
  endfunction

  assign hit = scan(bits);
endmodule

// File: rtl/rds_tx.sv
module rds_tx
  import rds_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int L  = PAT_L,
  parameter int M  = PAT_M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_data,
  output logic          out_valid,
  output logic          out_flag,
  output logic [FW-1:0] out_data,
  output logic [FW-1:0] stage1,
  output logic          rep_hit,
  output logic          sec_adv,
  output logic [SEC_W-1:0] sec_state,
  output logic [PRI_W-1:0] pri_state
);
  logic          accept;
  logic [FW-1:0] key1, key2;

  assign accept  = in_valid & in_ready;
  assign sec_adv = accept & rep_hit;
  assign stage1  = in_data ^ key1;

  rds_lfsr #(.SW(PRI_W), .FW(FW), .MASK(PRI_MASK), .SEED(PRI_SEED)) u_pri (
    .clk(clk), .rst_n(rst_n), .adv(accept), .key(key1), .state(pri_state));

  rds_repeat_det #(.FW(FW), .L(L), .M(M)) u_det (.bits(stage1), .hit(rep_hit));

  rds_lfsr #(.SW(SEC_W), .FW(FW), .MASK(SEC_MASK), .SEED(SEC_SEED)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv(sec_adv), .key(key2), .state(sec_state));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      out_flag  <= 1'b0;
      out_data  <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept;
      if (accept) begin
        out_flag <= rep_hit;
        out_data <= rep_hit ? (stage1 ^ key2) : stage1;
      end
    end
  end
endmodule

// File: rtl/rds_rx.sv
module rds_rx
  import rds_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_flag,
  input  logic [FW-1:0] rx_data,
  output logic          dec_valid,
  output logic [FW-1:0] dec_data,
  output logic          sec_adv,
  output logic [SEC_W-1:0] sec_state,
  output logic [PRI_W-1:0] pri_state
);
  logic [FW-1:0] key1, key2, undo2, undo1;

  assign sec_adv = rx_valid & rx_flag;
  assign undo2   = rx_flag ? (rx_data ^ key2) : rx_data;
  assign undo1   = undo2 ^ key1;

  rds_lfsr #(.SW(SEC_W), .FW(FW), .MASK(SEC_MASK), .SEED(SEC_SEED)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv(sec_adv), .key(key2), .state(sec_state));

  rds_lfsr #(.SW(PRI_W), .FW(FW), .MASK(PRI_MASK), .SEED(PRI_SEED)) u_pri (
    .clk(clk), .rst_n(rst_n), .adv(rx_valid), .key(key1), .state(pri_state));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_data  <= '0;
    end else begin
      dec_valid <= rx_valid;
      if (rx_valid) dec_data <= undo1;
    end
  end
endmodule

// File: rtl/rep_scrambler_link.sv
module rep_scrambler_link
  import rds_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int L  = PAT_L,
  parameter int M  = PAT_M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_data,
  output logic          out_valid,
  output logic          out_flag,
  output logic [FW-1:0] out_data,
  input  logic          rx_valid,
  input  logic          rx_flag,
  input  logic [FW-1:0] rx_data,
  output logic          dec_valid,
  output logic [FW-1:0] dec_data
);
  logic [FW-1:0]    tx_stage1;
  logic             tx_rep_hit;
  logic             tx_sec_adv;
  logic [SEC_W-1:0] tx_sec_state;
  logic [PRI_W-1:0] tx_pri_state;
  logic             rx_sec_adv;
  logic [SEC_W-1:0] rx_sec_state;
  logic [PRI_W-1:0] rx_pri_state;

  rds_tx #(.FW(FW), .L(L), .M(M)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_flag(out_flag),
    .out_data(out_data), .stage1(tx_stage1), .rep_hit(tx_rep_hit),
    .sec_adv(tx_sec_adv), .sec_state(tx_sec_state), .pri_state(tx_pri_state));

  rds_rx #(.FW(FW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flag(rx_flag),
    .rx_data(rx_data), .dec_valid(dec_valid), .dec_data(dec_data),
    .sec_adv(rx_sec_adv), .sec_state(rx_sec_state), .pri_state(rx_pri_state));
endmodule

// File: rtl/rep_scrambler_link_chk.sv
module rep_scrambler_link_chk
  import rds_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_flag,
  input logic [FW-1:0] out_data,
  input logic          rx_valid,
  input logic          dec_valid,
  input logic [FW-1:0] tx_stage1,
  input logic          tx_rep_hit,
  input logic          tx_sec_adv,
  input logic [SEC_W-1:0] tx_sec_state,
  input logic [PRI_W-1:0] tx_pri_state,
  input logic          rx_sec_adv,
  input logic [SEC_W-1:0] rx_sec_state,
  input logic [PRI_W-1:0] rx_pri_state
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);
  p_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flag) |-> out_data == $past(tx_stage1));
  p_pri_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pri_state != '0 && rx_pri_state != '0);
  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flag == $past(tx_rep_hit));
  p_sec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sec_adv |=> $stable(tx_sec_state));
  p_altered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag) |-> out_data != $past(tx_stage1));
  p_dec_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> dec_valid);
  p_dec_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !dec_valid);
  p_rx_sec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sec_adv |=> $stable(rx_sec_state));
endmodule

bind rep_scrambler_link rep_scrambler_link_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_flag(out_flag), .out_data(out_data),
  .rx_valid(rx_valid), .dec_valid(dec_valid), .tx_stage1(tx_stage1),
  .tx_rep_hit(tx_rep_hit), .tx_sec_adv(tx_sec_adv), .tx_sec_state(tx_sec_state),
  .tx_pri_state(tx_pri_state), .rx_sec_adv(rx_sec_adv),
  .rx_sec_state(rx_sec_state), .rx_pri_state(rx_pri_state));

// File: tb/rep_scrambler_link_bench.sv
module rep_scrambler_link_bench;
  localparam int FW = 64;
  localparam int L  = 8;
  localparam int M  = 5;
  localparam int NMAX = 1024;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          in_valid = 0;
  logic [FW-1:0] in_data = '0;
  logic          in_ready, out_valid, out_flag, dec_valid;
  logic [FW-1:0] out_data, dec_data;

  always #2 clk = ~clk;

  rep_scrambler_link u_rep_scrambler_link (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_flag(out_flag),
    .out_data(out_data), .rx_valid(out_valid), .rx_flag(out_flag),
    .rx_data(out_data), .dec_valid(dec_valid), .dec_data(dec_data));

  int checks = 0, errors = 0, flagged = 0;
  int n_sent = 0, oi = 0, di = 0;
  bit running = 0, done = 0, ov_prev = 0;
  logic [FW-1:0] q_in [NMAX];
  logic [FW-1:0] q_out[NMAX];
  logic [FW-1:0] q_s1 [NMAX];
  logic          q_flg[NMAX];
  logic [31:0]   m_pri = 32'hFFFF;
  logic [31:0]   m_sec = 32'h7FFFFF;

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] keys(input logic [31:0] st, input int w, input logic [31:0] taps);
    logic [FW-1:0] k = '0;
    logic top;
    for (int n = 0; n < FW; n++) begin
      top = st[w-1];
      k = {k[FW-2:0], top};
      st = (st << 1) & ((32'd1 << w) - 1);
      if (top) st = st ^ taps;
    end
    return k;
  endfunction

  function automatic logic [31:0] stepped(input logic [31:0] st, input int w, input logic [31:0] taps);
    logic top;
    for (int n = 0; n < FW; n++) begin
      top = st[w-1];
      st = (st << 1) & ((32'd1 << w) - 1);
      if (top) st = st ^ taps;
    end
    return st;
  endfunction

  function automatic bit periodic(input logic [FW-1:0] s);
    for (int off = 0; off <= FW - L*M; off++) begin
      bit same = 1;
      for (int i = 0; i < L*(M-1); i++)
        if (s[off+i] != s[off+i+L]) same = 0;
      if (same) return 1;
    end
    return 0;
  endfunction

  task automatic send(input logic [FW-1:0] d);
    logic [FW-1:0] s1;
    bit f;
    @(negedge clk); #1;
    in_valid = 1; in_data = d;
    s1 = d ^ keys(m_pri, 16, 32'h0039);
    f  = periodic(s1);
    q_in[n_sent] = d; q_s1[n_sent] = s1; q_flg[n_sent] = f;
    if (f) begin
      q_out[n_sent] = s1 ^ keys(m_sec, 23, 32'h210125);
      m_sec = stepped(m_sec, 23, 32'h210125);
      flagged++;
    end else q_out[n_sent] = s1;
    m_pri = stepped(m_pri, 16, 32'h0039);
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; in_valid = 0;
    end
  endtask

  // Build input whose stage-1 result has `reps` copies of `b` at bit `off`
  task automatic send_rep(input int off, input logic [7:0] b, input int reps);
    logic [FW-1:0] t = {$urandom, $urandom};
    for (int j = 0; j < L*reps; j++) t[off+j] = b[j%L];
    if (off > 0) t[off-1] = ~t[off-1+L];
    if (off + L*reps < FW) t[off+L*reps] = ~t[off+L*reps-L];
    send(t ^ keys(m_pri, 16, 32'h0039));
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(out_valid == in_valid, "R2 out_valid", 64'(out_valid), 64'(in_valid));
      if (out_valid) begin
        chk(out_flag == q_flg[oi], "R4/R6 flag", 64'(out_flag), 64'(q_flg[oi]));
        chk(out_data == q_out[oi], q_flg[oi] ? "R5 data" : "R3 data", out_data, q_out[oi]);
        if (q_flg[oi]) chk(out_data != q_s1[oi], "R9 altered", out_data, q_s1[oi]);
        oi++;
      end
      chk(dec_valid == ov_prev, "R7 dec_valid", 64'(dec_valid), 64'(ov_prev));
      if (dec_valid) begin
        chk(dec_data == q_in[di], "R7/R8 recovered", dec_data, q_in[di]);
        di++;
      end
      ov_prev = out_valid;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !dec_valid, "R1 reset outputs",
        64'({in_ready, out_valid, dec_valid}), 64'd0);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 ready", 64'(in_ready), 64'd1);
    running = 1;
    send_rep(24, 8'hA5, 5);           // R4 top offset
    send_rep(0, 8'h3C, 5);            // R4 bottom offset
    send_rep(13, 8'h96, 5);           // R4 unaligned
    send_rep(20, 8'h5A, 4);           // R4 one repeat short
    send(64'h0 ^ keys(m_pri, 16, 32'h0039)); // all-zero stage 1
    idle(2);
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) == 0) send_rep($urandom_range(0, FW - L*M), 8'($urandom), M);
      else send({$urandom, $urandom});
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end
    for (int i = 0; i < 6; i++) begin // R8 alternate flagged/unflagged back to back
      send_rep(8, 8'hC3, M);
      send({$urandom, $urandom});
    end
    idle(4);
    running = 0;
    chk(flagged >= 10, "R4 flagged count", 64'(flagged), 64'd10);
    chk(oi == n_sent && di == n_sent, "R7 frame count", 64'(di), 64'(n_sent));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", oi, n_sent);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule